// File: doc/BRIEF.md
# Single-Bit Shift and Rotate Unit

This block executes one shift step on an 8-bit register operand for a small processor datapath. It checks the instruction word for the shift opcode, then reads a direction bit and a 3-bit fill selector from that word. The operand moves one bit position. The vacated bit position is loaded from one of five sources: the incoming carry, the operand's top bit, the operand's bottom bit, a constant 0 or a constant 1. This single datapath therefore covers the following variants in both directions:

- shift in a zero;
- shift in a one;
- arithmetic (sign-preserving) right shift;
- repeat of the low bit on a left shift;
- rotate through carry.

The bit pushed out of the operand always becomes the new carry. The zero flag reports an all-zero result.

The register file and the rest of instruction decode sit outside the block. The caller presents the operand and the current carry flag with `valid_i`. One clock later it takes back the result, the new carry and the new zero flag. Instruction words that are not shifts leave all outputs unchanged.

Top module: `shift_rotate_unit`

## Requirements
- R1: While `rst_ni` is low, and after its release until the first accepted shift, `done_o`, `result_o`, `carry_o` and `zero_o` are all 0.
- R2: A shift is accepted when `valid_i` is 1 and `instr_i[17:12]` equals 6'b100000. On acceptance `done_o` is 1 in the following cycle. In any other cycle `done_o` is 0 in the following cycle and `result_o`, `carry_o` and `zero_o` hold their values.
- R3: `instr_i[3]` selects the direction. With 0 (left) the result is `{operand[6:0], fill}`. With 1 (right) the result is `{fill, operand[7:1]}`.
- R4: `instr_i[2:0]` selects the fill bit:
  - 3'b000 or 3'b001 selects `carry_i`;
  - 3'b010 or 3'b011 selects `operand[7]`;
  - 3'b100 or 3'b101 selects `operand[0]`;
  - 3'b110 selects 0;
  - 3'b111 selects 1.
- R5: `carry_o` takes the outgoing bit: `operand[7]` for a left shift and `operand[0]` for a right shift. With carry fill, the old `carry_i` goes into the result.
- R6: `zero_o` is 1 exactly when the new `result_o` is 8'h00.
- R7: `instr_i[11:4]` (register index and padding) has no effect on the result or the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction word and operand are present |
| instr_i | input | 18 | Instruction word |
| operand_i | input | 8 | Register operand |
| carry_i | input | 1 | Current carry flag |
| done_o | output | 1 | A shift was performed in the previous cycle |
| result_o | output | 8 | Shifted byte |
| carry_o | output | 1 | New carry flag |
| zero_o | output | 1 | New zero flag |

## Verification
A wrong fill-source decode shows up in `result_o` on the cycle right after the shift, and only in the single vacated bit position. For that reason the operand sweep covers every selector code in both directions, with the incoming carry at both values. A carry taken from the wrong end of the operand, or updated before the fill is taken, shows up at once in `carry_o`. It also corrupts the chained six-step sequences, whose intermediate values depend on each earlier carry. A flag register that wrongly loads on a non-shift word shows up as a changed held output one cycle later.

// File: rtl/shift_rotate_pkg.sv
package shift_rotate_pkg;
  localparam int OPC_W = 6;
  localparam logic [OPC_W-1:0] SHIFT_OPC = 6'b100000;

  typedef enum logic [1:0] {
    FILL_CARRY = 2'b00,
    FILL_MSB   = 2'b01,
    FILL_LSB   = 2'b10,
    FILL_CONST = 2'b11
  } fill_src_e;

  typedef struct packed {
    logic      dir_right;
    fill_src_e src;
    logic      const_bit;
  } shift_ctl_t;
endpackage

// File: rtl/shift_field_decode.sv
module shift_field_decode
  import shift_rotate_pkg::*;
#(
  parameter int INSTR_W = 18
) (
  input  logic [INSTR_W-1:0] instr_i,
  output logic               is_shift_o,
  output shift_ctl_t         ctl_o
);
  localparam int OPC_LSB = INSTR_W - OPC_W;

  assign is_shift_o = (instr_i[INSTR_W-1:OPC_LSB] == SHIFT_OPC);

  always_comb begin
    ctl_o.dir_right = instr_i[3];
    ctl_o.src       = fill_src_e'(instr_i[2:1]);
    ctl_o.const_bit = instr_i[0];
  end
endmodule

// File: rtl/shift_fill_mux.sv
module shift_fill_mux
  import shift_rotate_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  shift_ctl_t        ctl_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic              carry_i,
  output logic              fill_o
);
  always_comb begin
    unique case (ctl_i.src)
      FILL_CARRY: fill_o = carry_i;
      FILL_MSB:   fill_o = operand_i[DATA_W-1];
      FILL_LSB:   fill_o = operand_i[0];
      default:    fill_o = ctl_i.const_bit;
    endcase
  end
endmodule

// File: rtl/shift_core.sv
module shift_core #(
  parameter int DATA_W = 8
) (
  input  logic              dir_right_i,
  input  logic              fill_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              zero_o
);
  logic [DATA_W-1:0] left_res, right_res;

  assign left_res  = {operand_i[DATA_W-2:0], fill_i};
  assign right_res = {fill_i, operand_i[DATA_W-1:1]};

  always_comb begin
    if (dir_right_i) begin
      result_o = right_res;
      carry_o  = operand_i[0];
    end else begin
      result_o = left_res;
      carry_o  = operand_i[DATA_W-1];
    end
    zero_o = (result_o == '0);
  end
endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
  import shift_rotate_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int INSTR_W = 18
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [DATA_W-1:0]  operand_i,
  input  logic               carry_i,
  output logic               done_o,
  output logic [DATA_W-1:0]  result_o,
  output logic               carry_o,
  output logic               zero_o
);
  logic              is_shift, fill, nxt_carry, nxt_zero;
  logic [DATA_W-1:0] nxt_result;
  shift_ctl_t        ctl;

  shift_field_decode #(.INSTR_W(INSTR_W)) u_dec (
    .instr_i   (instr_i),
    .is_shift_o(is_shift),
    .ctl_o     (ctl)
  );

  shift_fill_mux #(.DATA_W(DATA_W)) u_fill (
    .ctl_i    (ctl),
    .operand_i(operand_i),
    .carry_i  (carry_i),
    .fill_o   (fill)
  );

  shift_core #(.DATA_W(DATA_W)) u_core (
    .dir_right_i(ctl.dir_right),
    .fill_i     (fill),
    .operand_i  (operand_i),
    .result_o   (nxt_result),
    .carry_o    (nxt_carry),
    .zero_o     (nxt_zero)
  );

  wire accept = valid_i & is_shift;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      result_o <= '0;
      carry_o  <= 1'b0;
      zero_o   <= 1'b0;
    end else begin
      done_o <= accept;
      if (accept) begin
        result_o <= nxt_result;
        carry_o  <= nxt_carry;
        zero_o   <= nxt_zero;
      end
    end
  end
endmodule

// File: rtl/shift_rotate_checker.sv
module shift_rotate_checker #(
  parameter int DATA_W  = 8,
  parameter int INSTR_W = 18
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic [INSTR_W-1:0] instr_i,
  input logic [DATA_W-1:0]  operand_i,
  input logic               carry_i,
  input logic               done_o,
  input logic [DATA_W-1:0]  result_o,
  input logic               carry_o,
  input logic               zero_o
);
  logic hit;
  assign hit = valid_i && (instr_i[INSTR_W-1 -: 6] == 6'b100000);

  p_done_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> done_o);
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> (!done_o && $stable(result_o) && $stable(carry_o) && $stable(zero_o)));
  p_right_body_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && instr_i[3]) |=> result_o[DATA_W-2:0] == $past(operand_i[DATA_W-1:1]));
  p_left_body_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !instr_i[3]) |=> result_o[DATA_W-1:1] == $past(operand_i[DATA_W-2:0]));
  p_one_fill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && instr_i[2:0] == 3'b111 && instr_i[3]) |=> result_o[DATA_W-1]);
  p_carry_fill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && instr_i[2:1] == 2'b00 && !instr_i[3]) |=> result_o[0] == $past(carry_i));
  p_carry_right_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && instr_i[3]) |=> carry_o == $past(operand_i[0]));
  p_carry_left_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !instr_i[3]) |=> carry_o == $past(operand_i[DATA_W-1]));
  p_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (zero_o == (result_o == '0)));
endmodule

bind shift_rotate_unit shift_rotate_checker #(.DATA_W(DATA_W), .INSTR_W(INSTR_W)) u_chk (.*);

// File: tb/shift_rotate_unit_tb.sv
module shift_rotate_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [17:0] instr = '0;
  logic [7:0]  operand = '0;
  logic        carry_in = 1'b0;
  logic        done;
  logic [7:0]  result;
  logic        carry_out, zero;
  int          total = 0, bad = 0;

  always #2 clk = ~clk;

  shift_rotate_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .instr_i(instr),
    .operand_i(operand), .carry_i(carry_in), .done_o(done),
    .result_o(result), .carry_o(carry_out), .zero_o(zero)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] mk(input logic [5:0] opc, input logic [7:0] mid,
                                     input logic dir, input logic [2:0] sel);
    return {opc, mid, dir, sel};
  endfunction

  // Expected model built from R3/R4/R5/R6
  function automatic logic [9:0] model(input logic [7:0] op, input logic c,
                                       input logic dir, input logic [2:0] sel);
    logic f;
    logic [7:0] r;
    logic co;
    case (sel)
      3'b000, 3'b001: f = c;
      3'b010, 3'b011: f = op[7];
      3'b100, 3'b101: f = op[0];
      3'b110:         f = 1'b0;
      default:        f = 1'b1;
    endcase
    if (dir) begin r = {f, op[7:1]}; co = op[0]; end
    else     begin r = {op[6:0], f}; co = op[7]; end
    return {r == 8'h00, co, r};
  endfunction

  task automatic apply(input logic v, input logic [17:0] ins, input logic [7:0] op, input logic c);
    @(negedge clk);
    valid = v; instr = ins; operand = op; carry_in = c;
    @(negedge clk);
  endtask

  task automatic run_seq(input string req, input logic [7:0] start, input logic dir,
                         input logic [2:0] sels [6], input logic [7:0] exps [6],
                         input logic [5:0] cexp);
    logic [7:0] cur = start;
    logic       c = 1'b0;
    for (int i = 0; i < 6; i++) begin
      apply(1'b1, mk(6'b100000, 8'h00, dir, sels[i]), cur, c);
      check(req, result, exps[i]);
      check(req, {7'd0, carry_out}, {7'd0, cexp[i]});
      cur = result;
      c = carry_out;
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    logic [9:0] e;
    logic [7:0] held;
    repeat (3) @(negedge clk);
    check("R1 done", {7'd0, done}, 8'h00);
    check("R1 result", result, 8'h00);
    check("R1 flags", {6'd0, carry_out, zero}, 8'h00);
    rst_n = 1'b1;
    apply(1'b0, mk(6'b100000, 8'h00, 1'b1, 3'b111), 8'hFF, 1'b1);
    check("R1 after release", {5'd0, done, carry_out, zero}, 8'h00);
    check("R1 result after release", result, 8'h00);

    // exhaustive sweep R3 R4 R5 R6 R7
    for (int op = 0; op < 256; op++)
      for (int d = 0; d < 2; d++)
        for (int s = 0; s < 8; s++)
          for (int c = 0; c < 2; c++) begin
            logic [7:0] mid = {op[7:4] ^ 4'(s), op[3:0] ^ 4'(c * 5)};
            e = model(8'(op), c[0], d[0], 3'(s));
            apply(1'b1, mk(6'b100000, mid, d[0], 3'(s)), 8'(op), c[0]);
            check("R3/R4/R7 result", result, e[7:0]);
            check("R5 carry", {7'd0, carry_out}, {7'd0, e[8]});
            check("R6 zero", {7'd0, zero}, {7'd0, e[9]});
            check("R2 done", {7'd0, done}, 8'h01);
          end

    // chained sequences from R3/R4/R5
    run_seq("R3 right chain", 8'h0F, 1'b1,
      '{3'b110, 3'b010, 3'b111, 3'b010, 3'b000, 3'b000},
      '{8'h07, 8'h03, 8'h81, 8'hC0, 8'hE0, 8'h70}, 6'b001111);
    run_seq("R4 left chain", 8'hF0, 1'b0,
      '{3'b110, 3'b100, 3'b111, 3'b100, 3'b000, 3'b000},
      '{8'hE0, 8'hC0, 8'h81, 8'h03, 8'h07, 8'h0E}, 6'b001111);

    // R2 hold on non-shift words and idle
    apply(1'b1, mk(6'b100000, 8'h00, 1'b0, 3'b111), 8'h00, 1'b0);
    held = result;
    check("R2 setup", held, 8'h01);
    apply(1'b1, mk(6'b100001, 8'h00, 1'b1, 3'b110), 8'h00, 1'b0);
    check("R2 wrong opcode done", {7'd0, done}, 8'h00);
    check("R2 wrong opcode hold", {result[6:0], carry_out}, {held[6:0], 1'b0});
    check("R2 wrong opcode zero", {7'd0, zero}, 8'h00);
    apply(1'b1, mk(6'b000000, 8'hFF, 1'b0, 3'b000), 8'h80, 1'b0);
    check("R2 opcode zero hold", result, held);
    apply(1'b0, mk(6'b100000, 8'h00, 1'b1, 3'b110), 8'h01, 1'b0);
    check("R2 idle done", {7'd0, done}, 8'h00);
    check("R2 idle hold", {result[6:0], carry_out, zero}, {held[6:0], 2'b00});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule